// File: doc/BRIEF.md
# Dual-Port RAM with Address-Collision Arbitration

This block is a synchronous memory with two identical access ports, left and right. Either port can read or write any word at any time. When both enabled ports point at the same word in the same cycle, an arbiter picks one port as the owner of that word. The other port gets a busy flag, and its write is suppressed inside the block. Reads are never suppressed. A port that is busy still reads, and it sees the contents as they were before the owner's write took effect.

A mode pin selects between two roles. With the pin high, the block is a master: its own arbiter drives the busy outputs and also gates the writes. With the pin low, the block is a slave: the busy outputs stay low, and the write gating comes from busy inputs fed by a master device. This lets several devices be ganged together for a wider word, with all of them following one arbitration decision.

Each data output is qualified by a valid flag. The flag stands in for a high-impedance output. The word size and address width are parameters. The default address width is 10 bits; setting it to 14 gives 16K words.

Top module: `dpr_collide_ram`

## Requirements
- R1: Both ports read and write every word. A write commits at the clock edge. A read issued in cycle n shows on that port's data output in cycle n+1. The address width is `ADDR_W` and the word width is `DATA_W`.
- R2: A collision means both chip enables are high and the two addresses are equal. In master mode, exactly one busy output is high during every collision cycle.
- R3: A port is "settled" when its enable was high in the previous cycle with the same address. If a collision starts while one port is settled and the other is not, the settled port wins and the newcomer is busy.
- R4: If a collision starts with both ports settled, or with neither settled, the left port wins and the right port is busy.
- R5: While a collision lasts, the winning port keeps ownership, whatever the settledness of either port.
- R6: When a collision ends, the loser's busy stays high for exactly one more cycle, then drops.
- R7: A write presented by a busy port is discarded, and the addressed word keeps its prior contents.
- R8: A busy port can still read. A read issued in the same cycle as the other port's write to that word returns the old contents. A read issued in a later cycle returns the new contents.
- R9: In slave mode (`master_mode`=0), both busy outputs are held at 0. Each port's write is gated only by that port's busy input, and the internal arbitration has no effect.
- R10: A data-valid flag is 1 in cycle n+1 only if, in cycle n, that port had its chip enable at 1, its write control at 0 (read) and its output enable at 1. Whenever the valid flag is 0, the data output reads 0. After reset, both valid flags and both busy outputs are 0.
- R11: If both ports write the same word in the same cycle with neither write blocked (possible only in slave mode), the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| master_mode | input | 1 | 1 = internal arbiter drives busy; 0 = busy taken from inputs |
| busy_in_l | input | 1 | Left write block from an external master (slave mode) |
| busy_in_r | input | 1 | Right write block from an external master (slave mode) |
| busy_out_l | output | 1 | Left port lost arbitration (master mode) |
| busy_out_r | output | 1 | Right port lost arbitration (master mode) |
| ce_l | input | 1 | Left chip enable |
| wr_l | input | 1 | Left write control, 1 = write, 0 = read |
| oe_l | input | 1 | Left output enable |
| addr_l | input | ADDR_W | Left word address |
| din_l | input | DATA_W | Left write data |
| dout_l | output | DATA_W | Left read data, 0 when not valid |
| dout_vld_l | output | 1 | Left read data is driven |
| ce_r | input | 1 | Right chip enable |
| wr_r | input | 1 | Right write control, 1 = write, 0 = read |
| oe_r | input | 1 | Right output enable |
| addr_r | input | ADDR_W | Right word address |
| din_r | input | DATA_W | Right write data |
| dout_r | output | DATA_W | Right read data, 0 when not valid |
| dout_vld_r | output | 1 | Right read data is driven |

## Verification
The busy outputs are a function of the current inputs and of one ownership register, so an error in the ownership state shows on a busy pin in the same cycle it arises. Such an error most often appears at the start of a collision, at a hand-over, or in the single cycle after a collision ends. A write that was wrongly allowed or wrongly blocked stays hidden until that word is read back; the bench therefore reads each contested word one or two cycles after the conflict and compares it with a behavioural reference. An error in a registered read path shows on the next cycle's data or valid flag.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          ce_l,
  input  logic [AW-1:0] addr_l,
  input  logic          ce_r,
  input  logic [AW-1:0] addr_r,
  output logic          coll_o,
  output logic          busy_l_o,
  output logic          busy_r_o
);
  logic          prev_ce_l_q, prev_ce_r_q;
  logic [AW-1:0] prev_addr_l_q, prev_addr_r_q;
  owner_e        owner_q, owner_d;
  logic          settled_l, settled_r;

  // next-state logic
  always_comb begin
    coll_o    = ce_l && ce_r && (addr_l == addr_r);
    settled_l = ce_l && prev_ce_l_q && (addr_l == prev_addr_l_q);
    settled_r = ce_r && prev_ce_r_q && (addr_r == prev_addr_r_q);
    if (!coll_o)                       owner_d = OWN_NONE;
    else if (owner_q != OWN_NONE)      owner_d = owner_q;
    else if (settled_r && !settled_l)  owner_d = OWN_RIGHT;
    else                               owner_d = OWN_LEFT;
    busy_l_o = (owner_d == OWN_RIGHT) || (owner_q == OWN_RIGHT);
    busy_r_o = (owner_d == OWN_LEFT)  || (owner_q == OWN_LEFT);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q     <= OWN_NONE;
      prev_ce_l_q <= 1'b0;
      prev_ce_r_q <= 1'b0;
    end else begin
      owner_q     <= owner_d;
      prev_ce_l_q <= ce_l;
      prev_ce_r_q <= ce_r;
    end
  end

  // address history, loaded only while the port is enabled
  always_ff @(posedge clk) begin
    if (ce_l) prev_addr_l_q <= addr_l;
    if (ce_r) prev_addr_r_q <= addr_r;
  end

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_ni)
    coll_o |-> (busy_l_o != busy_r_o)); // R2

  AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_ni)
    (coll_o && $past(coll_o) && $past(busy_r_o)) |-> busy_r_o); // R5

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_ni)
    (!coll_o && $past(!coll_o)) |-> (!busy_l_o && !busy_r_o)); // R6
endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          wr_i,
  input  logic          oe_i,
  input  logic          blk_i,
  input  logic [DW-1:0] rd_word_i,
  output logic          we_o,
  output logic [DW-1:0] dout_o,
  output logic          dout_vld_o
);
  logic          rd_fire;
  logic          vld_d, vld_q;
  logic [DW-1:0] data_q;

  always_comb begin
    rd_fire = ce_i && !wr_i;
    vld_d   = rd_fire && oe_i;
    we_o    = ce_i && wr_i && !blk_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= vld_d;
  end

  // read data register with explicit load enable
  always_ff @(posedge clk) begin
    if (rd_fire) data_q <= rd_word_i;
  end

  assign dout_o     = vld_q ? data_q : '0;
  assign dout_vld_o = vld_q;
endmodule

// File: rtl/dpr_storage.sv
module dpr_storage #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we_l,
  input  logic [AW-1:0] addr_l,
  input  logic [DW-1:0] din_l,
  input  logic          we_r,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] din_r,
  output logic [DW-1:0] rd_l,
  output logic [DW-1:0] rd_r
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // right first, so the left write lands last on a shared word
  always_ff @(posedge clk) begin
    if (we_r) mem[addr_r] <= din_r;
    if (we_l) mem[addr_l] <= din_l;
  end

  assign rd_l = mem[addr_l];
  assign rd_r = mem[addr_r];
endmodule

// File: rtl/dpr_collide_ram.sv
module dpr_collide_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              busy_in_l,
  input  logic              busy_in_r,
  output logic              busy_out_l,
  output logic              busy_out_r,
  input  logic              ce_l,
  input  logic              wr_l,
  input  logic              oe_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] din_l,
  output logic [DATA_W-1:0] dout_l,
  output logic              dout_vld_l,
  input  logic              ce_r,
  input  logic              wr_r,
  input  logic              oe_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] din_r,
  output logic [DATA_W-1:0] dout_r,
  output logic              dout_vld_r
);
  localparam int NPORT = 2;

  logic              rst_sync_n;
  logic              coll;
  logic              arb_busy_l, arb_busy_r;
  logic              ce_v   [NPORT];
  logic              wr_v   [NPORT];
  logic              oe_v   [NPORT];
  logic              blk_v  [NPORT];
  logic              we_v   [NPORT];
  logic              vld_v  [NPORT];
  logic [DATA_W-1:0] rd_v   [NPORT];
  logic [DATA_W-1:0] dout_v [NPORT];

  dpr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_no(rst_sync_n)
  );

  dpr_arbiter #(.AW(ADDR_W)) u_arb (
    .clk(clk), .rst_ni(rst_sync_n),
    .ce_l(ce_l), .addr_l(addr_l), .ce_r(ce_r), .addr_r(addr_r),
    .coll_o(coll), .busy_l_o(arb_busy_l), .busy_r_o(arb_busy_r)
  );

  always_comb begin
    busy_out_l = master_mode ? arb_busy_l : 1'b0;
    busy_out_r = master_mode ? arb_busy_r : 1'b0;
    blk_v[0]   = master_mode ? arb_busy_l : busy_in_l;
    blk_v[1]   = master_mode ? arb_busy_r : busy_in_r;
    ce_v[0] = ce_l;  wr_v[0] = wr_l;  oe_v[0] = oe_l;
    ce_v[1] = ce_r;  wr_v[1] = wr_r;  oe_v[1] = oe_r;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port #(.DW(DATA_W)) u_port (
      .clk(clk), .rst_ni(rst_sync_n),
      .ce_i(ce_v[p]), .wr_i(wr_v[p]), .oe_i(oe_v[p]), .blk_i(blk_v[p]),
      .rd_word_i(rd_v[p]), .we_o(we_v[p]),
      .dout_o(dout_v[p]), .dout_vld_o(vld_v[p])
    );
  end

  dpr_storage #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk),
    .we_l(we_v[0]), .addr_l(addr_l), .din_l(din_l),
    .we_r(we_v[1]), .addr_r(addr_r), .din_r(din_r),
    .rd_l(rd_v[0]), .rd_r(rd_v[1])
  );

  assign dout_l     = dout_v[0];
  assign dout_vld_l = vld_v[0];
  assign dout_r     = dout_v[1];
  assign dout_vld_r = vld_v[1];

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !master_mode |-> (!busy_out_l && !busy_out_r)); // R9

  AST_BUSY_NO_WRITE_L: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (master_mode && busy_out_l) |-> !we_v[0]); // R7

  AST_BUSY_NO_WRITE_R: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (master_mode && busy_out_r) |-> !we_v[1]); // R7

  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dout_vld_l |-> $past(ce_l && !wr_l && oe_l)); // R10

  AST_COLL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (master_mode && coll) |-> (busy_out_l || busy_out_r)); // R2
endmodule

// File: tb/dpr_collide_ram_test.sv
module dpr_collide_ram_test;
  localparam int PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk, rst_n, master_mode, busy_in_l, busy_in_r;
  logic busy_out_l, busy_out_r;
  logic ce_l, wr_l, oe_l, ce_r, wr_r, oe_r;
  logic [AW-1:0] addr_l, addr_r;
  logic [DW-1:0] din_l, din_r, dout_l, dout_r;
  logic dout_vld_l, dout_vld_r;

  dpr_collide_ram #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .busy_in_l(busy_in_l), .busy_in_r(busy_in_r),
    .busy_out_l(busy_out_l), .busy_out_r(busy_out_r),
    .ce_l(ce_l), .wr_l(wr_l), .oe_l(oe_l), .addr_l(addr_l), .din_l(din_l),
    .dout_l(dout_l), .dout_vld_l(dout_vld_l),
    .ce_r(ce_r), .wr_r(wr_r), .oe_r(oe_r), .addr_r(addr_r), .din_r(din_r),
    .dout_r(dout_r), .dout_vld_r(dout_vld_r)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  int ref_m [DEPTH];
  bit known [DEPTH];
  int own = 0;                 // 0 none, 1 left, 2 right
  bit pce_l = 0, pce_r = 0;
  int pa_l = 0, pa_r = 0;
  int eq_l = 0, eq_r = 0;
  bit ev_l = 0, ev_r = 0, ek_l = 0, ek_r = 0;

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drv_l(input bit ce, input bit wr, input bit oe, input int a, input int d);
    ce_l = ce; wr_l = wr; oe_l = oe; addr_l = AW'(a); din_l = DW'(d);
  endtask

  task automatic drv_r(input bit ce, input bit wr, input bit oe, input int a, input int d);
    ce_r = ce; wr_r = wr; oe_r = oe; addr_r = AW'(a); din_r = DW'(d);
  endtask

  // one clock: compare against the model, then advance the model
  task automatic step(input string tag);
    bit coll, st_l, st_r, ib_l, ib_r, eff_l, eff_r;
    int win, al, ar;
    al = int'(addr_l); ar = int'(addr_r);
    coll = ce_l && ce_r && (al == ar);
    st_l = ce_l && pce_l && (al == pa_l);
    st_r = ce_r && pce_r && (ar == pa_r);
    if (!coll) win = 0;
    else if (own != 0) win = own;
    else if (st_r && !st_l) win = 2;
    else win = 1;
    ib_l = (win == 2) || (own == 2);
    ib_r = (win == 1) || (own == 1);
    eff_l = master_mode ? ib_l : busy_in_l;
    eff_r = master_mode ? ib_r : busy_in_r;
    #1;
    chk(tag, "busy_out_l", int'(busy_out_l), master_mode ? int'(ib_l) : 0);
    chk(tag, "busy_out_r", int'(busy_out_r), master_mode ? int'(ib_r) : 0);
    chk(tag, "dout_vld_l", int'(dout_vld_l), int'(ev_l));
    chk(tag, "dout_vld_r", int'(dout_vld_r), int'(ev_r));
    if (!ev_l) chk(tag, "dout_l idle", int'(dout_l), 0);
    else if (ek_l) chk(tag, "dout_l", int'(dout_l), eq_l);
    if (!ev_r) chk(tag, "dout_r idle", int'(dout_r), 0);
    else if (ek_r) chk(tag, "dout_r", int'(dout_r), eq_r);
    // reads see memory before this cycle's writes
    if (ce_l && !wr_l) begin eq_l = ref_m[al]; ek_l = known[al]; end
    if (ce_r && !wr_r) begin eq_r = ref_m[ar]; ek_r = known[ar]; end
    ev_l = ce_l && !wr_l && oe_l;
    ev_r = ce_r && !wr_r && oe_r;
    if (ce_r && wr_r && !eff_r) begin ref_m[ar] = int'(din_r); known[ar] = 1; end
    if (ce_l && wr_l && !eff_l) begin ref_m[al] = int'(din_l); known[al] = 1; end
    own = win;
    pce_l = ce_l; pce_r = ce_r; pa_l = al; pa_r = ar;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      drv_l(0, 0, 0, 0, 0); drv_r(0, 0, 0, 0, 0);
      step(tag);
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    rst_n = 1'b0; master_mode = 1'b1; busy_in_l = 1'b0; busy_in_r = 1'b0;
    drv_l(0, 0, 0, 0, 0); drv_r(0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R10", 4);   // reset state: no busy, nothing valid

    // R1: fill two regions concurrently, then read back across ports
    for (int i = 0; i < 32; i++) begin
      drv_l(1, 1, 0, i, 16'h1000 + i); drv_r(1, 1, 0, 32 + i, 16'h2000 + i);
      step("R1");
    end
    for (int i = 0; i < 8; i++) begin
      drv_l(1, 0, 1, 40 + i, 0); drv_r(1, 0, 1, i, 0);
      step("R1");
    end
    // R10: output enable low or write cycle gives no valid data
    for (int i = 0; i < 6; i++) begin
      drv_l(1, 0, i % 2, i, 0); drv_r(i % 3 != 0, i % 3 == 1, 1, 50 + i, 16'h3300 + i);
      step("R10");
    end
    idle("R10", 2);

    // R4: simultaneous arrival writing word 5, left wins
    drv_l(1, 1, 0, 5, 16'hAAAA); drv_r(1, 1, 0, 5, 16'hBBBB);
    step("R4");
    step("R5");
    step("R5");
    idle("R6", 2);                  // one lingering busy cycle then clear
    drv_l(1, 0, 1, 5, 0); step("R7");
    idle("R7", 2);

    // R3: right settles on word 7 first, left arrives and loses
    drv_r(1, 0, 1, 7, 0); step("R3");
    drv_l(1, 1, 0, 7, 16'hCCCC); step("R3");
    step("R7");
    drv_r(0, 0, 0, 0, 0); step("R6");   // lingering busy blocks left
    step("R6");                         // now left write goes through
    drv_l(0, 0, 0, 0, 0); drv_r(1, 0, 1, 7, 0); step("R7");
    idle("R7", 2);

    // R8: busy right port reads while left writes word 9
    drv_l(1, 0, 1, 9, 0); step("R8");
    drv_l(1, 1, 0, 9, 16'hDDDD); drv_r(1, 0, 1, 9, 0); step("R8");
    drv_l(0, 0, 0, 0, 0); step("R8");
    step("R8");
    idle("R8", 2);

    // R2: reads colliding on word 20, both arriving together again
    drv_l(1, 0, 1, 20, 0); drv_r(1, 0, 1, 20, 0); step("R2");
    step("R2");
    idle("R2", 2);

    // R9: slave mode, external busy gates writes
    master_mode = 1'b0;
    busy_in_r = 1'b1;
    drv_l(1, 0, 1, 11, 0); drv_r(1, 1, 0, 10, 16'hEEEE); step("R9");
    busy_in_r = 1'b0;
    drv_l(1, 0, 1, 10, 0); drv_r(1, 0, 1, 10, 0); step("R9");
    idle("R9", 2);
    busy_in_l = 1'b1;
    drv_l(1, 1, 0, 13, 16'h4444); step("R9");
    busy_in_l = 1'b0;
    drv_l(1, 0, 1, 13, 0); step("R9");
    idle("R9", 2);

    // R11: unblocked same-word writes, left data kept
    drv_l(1, 1, 0, 12, 16'h1111); drv_r(1, 1, 0, 12, 16'h2222); step("R11");
    drv_l(0, 0, 0, 0, 0); drv_r(1, 0, 1, 12, 0); step("R11");
    idle("R11", 2);

    master_mode = 1'b1;
    idle("R10", 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule